// File: doc/BRIEF.md
# Replica-Path Margin Monitor

This block measures eye margin on a parallel, interleaved decision-feedback receiver without touching live data. A replica of one selection-based equalizer lane takes its thermometer comparator word and decision history from a lane picked by software. One comparator in that copy, also picked by software, is replaced by a spare comparator whose threshold can be moved independently. The replica decision is XORed with the live decision of the same lane, and every disagreement counts as a pseudo error. Sweeping the spare threshold and reading the error count per setting traces the margin of each partial-response eye.

A measurement starts on a pulse, counts compared bits up to a programmed window, then raises a done flag and holds its counts until it is cleared or restarted. A second mode checks the selected lane's live decisions against a PRBS31 sequence. It seeds a local generator from the incoming stream and then counts true bit errors.

Top module: `margin_monitor`

## Requirements
- R1: After reset, busy_o and done_o are 0 and bit_cnt_o and err_cnt_o are 0.
- R2: The replica decision takes the selected lane's comparator word, replaces bit cmp_sel_i with spare_i, and picks the bit whose index is held in field h of map_i (bits [h*4 +: 4] for the default of 16 comparators). Here h is the selected lane's 2-bit history. Lane l owns cmp_i[l*16 +: 16], hist_i[l*2 +: 2] and dec_i[l].
- R3: In pseudo mode (prbs_mode_i = 0), each valid_i cycle during a run adds 1 to bit_cnt_o, and adds 1 to err_cnt_o when the replica decision differs from the selected lane's live decision. Counts show on the cycle after the sampling edge.
- R4: When bit_cnt_o reaches window_i, busy_o falls and done_o rises at the same edge. Further valid_i cycles leave both counts unchanged.
- R5: err_cnt_o is 11 bits wide and stays at 2047 instead of wrapping.
- R6: A clear_i pulse zeroes both counts and drops busy_o and done_o.
- R7: A change on lane_sel_i or cmp_sel_i aborts the run at the same edge: counts go to 0 and busy_o and done_o go to 0. This takes priority over start_i.
- R8: In PRBS mode (prbs_mode_i = 1), the first 31 valid bits of a run seed the checker and are not counted. Each later bit is compared with the locally generated x^31+x^28+1 sequence, and the generator advances on its own prediction, so an isolated received error counts exactly once.
- R9: A start_i pulse zeroes both counts, clears done_o and raises busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One received bit per lane is present this cycle |
| cmp_i | input | 64 | Thermometer comparator words of all lanes |
| hist_i | input | 8 | Decision history of all lanes |
| dec_i | input | 4 | Live decisions of all lanes |
| spare_i | input | 1 | Spare comparator output |
| map_i | input | 16 | History-to-comparator assignment, 4 bits per history value |
| lane_sel_i | input | 2 | Lane feeding the replica |
| cmp_sel_i | input | 4 | Comparator replaced by the spare |
| prbs_mode_i | input | 1 | 0 pseudo error, 1 PRBS31 check |
| window_i | input | 16 | Compared bits per measurement |
| start_i | input | 1 | Begin a measurement |
| clear_i | input | 1 | Stop and zero the counts |
| busy_o | output | 1 | Measurement running |
| done_o | output | 1 | Window complete, counts frozen |
| bit_cnt_o | output | 16 | Compared bits |
| err_cnt_o | output | 11 | Errors, saturating |

## Verification
A wrong lane or comparator route in the replica shows up as a single wrong error count after a one-bit window, on the cycle after the sampled bit. Each table entry therefore drives the other lanes with inverted words to expose a misroute. A stuck run-state or window compare shows at once as a count that moves after done_o, or as done_o arriving at the wrong bit count. A PRBS generator that advances on received data rather than its own prediction turns one injected error into several counted errors within a few dozen bits.

// File: rtl/margin_monitor_pkg.sv
package margin_monitor_pkg;
  localparam int unsigned PRBS_LEN = 31;
  localparam int unsigned PRBS_TAP = 28;
  typedef enum logic {MODE_PSEUDO = 1'b0, MODE_PRBS = 1'b1} mon_mode_e;
endpackage

// File: rtl/mm_replica.sv
module mm_replica #(
  parameter int unsigned NUM_CMP  = 16,
  parameter int unsigned NUM_TAPS = 2,
  localparam int unsigned CMP_W   = $clog2(NUM_CMP),
  localparam int unsigned NHIST   = 2 ** NUM_TAPS
) (
  input  logic [NUM_CMP-1:0]     cmp_i,
  input  logic [NUM_TAPS-1:0]    hist_i,
  input  logic                   spare_i,
  input  logic [CMP_W-1:0]       cmp_sel_i,
  input  logic [NHIST*CMP_W-1:0] map_i,
  output logic                   rep_o
);
  logic [NUM_CMP-1:0] cmp_mod;
  logic [CMP_W-1:0]   pick;

  always_comb begin
    cmp_mod = cmp_i;
    cmp_mod[cmp_sel_i] = spare_i;
    pick  = map_i[hist_i*CMP_W +: CMP_W];
    rep_o = cmp_mod[pick];
  end
endmodule

// File: rtl/mm_prbs_chk.sv
module mm_prbs_chk
  import margin_monitor_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  input  logic bit_i,
  output logic seeded_o,
  output logic err_o
);
  localparam int unsigned SEED_W = $clog2(PRBS_LEN + 1);

  logic [PRBS_LEN-1:0] sr_q;
  logic [SEED_W-1:0]   seed_q;
  logic                pred;

  assign seeded_o = (seed_q == SEED_W'(PRBS_LEN));
  assign pred     = sr_q[PRBS_TAP-1] ^ sr_q[PRBS_LEN-1];
  assign err_o    = pred ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      seed_q <= '0;
    end else if (restart_i) begin
      seed_q <= '0;
    end else if (en_i) begin
      if (!seeded_o) begin
        sr_q   <= {sr_q[PRBS_LEN-2:0], bit_i};
        seed_q <= seed_q + 1'b1;
      end else begin
        sr_q   <= {sr_q[PRBS_LEN-2:0], pred};
      end
    end
  end

  // R8
  seed_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_o && !restart_i |=> seeded_o);
endmodule

// File: rtl/mm_meas_ctrl.sv
module mm_meas_ctrl #(
  parameter int unsigned BIT_W = 16,
  parameter int unsigned ERR_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             cnt_en_i,
  input  logic             err_i,
  input  logic [BIT_W-1:0] window_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BIT_W-1:0] bit_cnt_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [BIT_W-1:0] bit_nxt;
  assign bit_nxt = bit_cnt_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; done_o <= 1'b0; bit_cnt_o <= '0; err_cnt_o <= '0;
    end else if (abort_i || clear_i) begin
      busy_o <= 1'b0; done_o <= 1'b0; bit_cnt_o <= '0; err_cnt_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1; done_o <= 1'b0; bit_cnt_o <= '0; err_cnt_o <= '0;
    end else if (busy_o && cnt_en_i) begin
      bit_cnt_o <= bit_nxt;
      if (err_i && err_cnt_o != ERR_MAX) err_cnt_o <= err_cnt_o + 1'b1;
      if (bit_nxt == window_i) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  // R4
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !abort_i && !clear_i && !start_i |=> $stable(err_cnt_o) && $stable(bit_cnt_o));
  // R5
  err_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o == ERR_MAX && !abort_i && !clear_i && !start_i |=> err_cnt_o == ERR_MAX);
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> bit_cnt_o == '0 && err_cnt_o == '0 && !busy_o && !done_o);
  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !busy_o && !done_o && bit_cnt_o == '0);
  // R9
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !abort_i && !clear_i |=> busy_o && !done_o && err_cnt_o == '0);
endmodule

// File: rtl/margin_monitor.sv
module margin_monitor
  import margin_monitor_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned NUM_CMP   = 16,
  parameter int unsigned NUM_TAPS  = 2,
  parameter int unsigned BIT_W     = 16,
  parameter int unsigned ERR_W     = 11,
  localparam int unsigned LANE_W   = $clog2(NUM_LANES),
  localparam int unsigned CMP_W    = $clog2(NUM_CMP),
  localparam int unsigned NHIST    = 2 ** NUM_TAPS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [NUM_LANES*NUM_CMP-1:0]  cmp_i,
  input  logic [NUM_LANES*NUM_TAPS-1:0] hist_i,
  input  logic [NUM_LANES-1:0]          dec_i,
  input  logic                          spare_i,
  input  logic [NHIST*CMP_W-1:0]        map_i,
  input  logic [LANE_W-1:0]             lane_sel_i,
  input  logic [CMP_W-1:0]              cmp_sel_i,
  input  logic                          prbs_mode_i,
  input  logic [BIT_W-1:0]              window_i,
  input  logic                          start_i,
  input  logic                          clear_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [BIT_W-1:0]              bit_cnt_o,
  output logic [ERR_W-1:0]              err_cnt_o
);
  logic [NUM_CMP-1:0]  lane_cmp [NUM_LANES];
  logic [NUM_TAPS-1:0] lane_hist [NUM_LANES];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_cmp[l]  = cmp_i[l*NUM_CMP +: NUM_CMP];
    assign lane_hist[l] = hist_i[l*NUM_TAPS +: NUM_TAPS];
  end

  logic [LANE_W-1:0] lane_q;
  logic [CMP_W-1:0]  csel_q;
  logic              sel_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      csel_q <= '0;
    end else begin
      lane_q <= lane_sel_i;
      csel_q <= cmp_sel_i;
    end
  end
  assign sel_chg = (lane_q != lane_sel_i) || (csel_q != cmp_sel_i);

  logic      rep_dec, live_dec, pseudo_err, prbs_err, seeded, restart;
  mon_mode_e mode;

  assign mode     = mon_mode_e'(prbs_mode_i);
  assign live_dec = dec_i[lane_sel_i];

  mm_replica #(.NUM_CMP(NUM_CMP), .NUM_TAPS(NUM_TAPS)) u_replica (
    .cmp_i     (lane_cmp[lane_sel_i]),
    .hist_i    (lane_hist[lane_sel_i]),
    .spare_i   (spare_i),
    .cmp_sel_i (cmp_sel_i),
    .map_i     (map_i),
    .rep_o     (rep_dec)
  );
  assign pseudo_err = rep_dec ^ live_dec;

  assign restart = sel_chg || clear_i || start_i;

  mm_prbs_chk u_prbs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .en_i      (valid_i && busy_o && mode == MODE_PRBS),
    .bit_i     (live_dec),
    .seeded_o  (seeded),
    .err_o     (prbs_err)
  );

  logic cnt_en, err_sel;
  assign cnt_en  = valid_i && (mode == MODE_PSEUDO || seeded);
  assign err_sel = (mode == MODE_PRBS) ? prbs_err : pseudo_err;

  mm_meas_ctrl #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (sel_chg),
    .clear_i   (clear_i),
    .start_i   (start_i),
    .cnt_en_i  (cnt_en),
    .err_i     (err_sel),
    .window_i  (window_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .bit_cnt_o (bit_cnt_o),
    .err_cnt_o (err_cnt_o)
  );

  // R4
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R8
  seed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_PRBS && !seeded && !restart |=> $stable(bit_cnt_o));
endmodule

// File: tb/margin_monitor_test.sv
module margin_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [63:0] cmp = '0;
  logic [7:0]  hist = '0;
  logic [3:0]  dec = '0;
  logic        spare = 1'b0;
  logic [15:0] map = {4'd12, 4'd8, 4'd4, 4'd0};
  logic [1:0]  lane = '0;
  logic [3:0]  csel = '0;
  logic        prbs_mode = 1'b0;
  logic [15:0] window = 16'd1;
  logic        start = 1'b0;
  logic        clear = 1'b0;
  logic        busy, done;
  logic [15:0] bit_cnt;
  logic [10:0] err_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  margin_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cmp_i(cmp), .hist_i(hist),
    .dec_i(dec), .spare_i(spare), .map_i(map), .lane_sel_i(lane), .cmp_sel_i(csel),
    .prbs_mode_i(prbs_mode), .window_i(window), .start_i(start), .clear_i(clear),
    .busy_o(busy), .done_o(done), .bit_cnt_o(bit_cnt), .err_cnt_o(err_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // {lane, csel, hist, cmp word, live dec, spare, expected error}
  localparam logic [26:0] TBL [8] = '{
    {2'd0, 4'd0,  2'd0, 16'h0000, 1'b0, 1'b1, 1'b1},
    {2'd0, 4'd0,  2'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'd4,  2'd1, 16'h0010, 1'b1, 1'b0, 1'b1},
    {2'd1, 4'd4,  2'd2, 16'h0100, 1'b1, 1'b0, 1'b0},
    {2'd2, 4'd8,  2'd2, 16'h0000, 1'b1, 1'b1, 1'b0},
    {2'd3, 4'd12, 2'd3, 16'hFFFF, 1'b1, 1'b0, 1'b1},
    {2'd3, 4'd12, 2'd0, 16'hFFFE, 1'b0, 1'b0, 1'b0},
    {2'd2, 4'd3,  2'd0, 16'h0001, 1'b1, 1'b0, 1'b0}
  };

  task automatic drive_lane(input logic [1:0] l, input logic [15:0] w,
                            input logic [1:0] h, input logic d);
    for (int k = 0; k < 4; k++) begin
      cmp[k*16 +: 16] = (k == int'(l)) ? w : ~w;
      hist[k*2 +: 2]  = (k == int'(l)) ? h : ~h;
      dec[k]          = (k == int'(l)) ? d : ~d;
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  logic [30:0] gen;
  function automatic logic prbs_next();
    logic b;
    b = gen[27] ^ gen[30];
    gen = {gen[29:0], b};
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 bits", bit_cnt, 0); chk("R1 errs", err_cnt, 0);
    rst_n = 1'b1;
    step();

    // R2 R3 single-bit table
    for (int i = 0; i < 8; i++) begin
      lane  = TBL[i][26:25];
      csel  = TBL[i][24:21];
      spare = TBL[i][1];
      drive_lane(TBL[i][26:25], TBL[i][18:3], TBL[i][20:19], TBL[i][2]);
      window = 16'd1;
      step();
      pulse_start();
      valid = 1'b1; step(); valid = 1'b0;
      chk($sformatf("R2 R3 entry %0d err", i), err_cnt, int'(TBL[i][0]));
      chk($sformatf("R3 entry %0d bits", i), bit_cnt, 1);
      chk($sformatf("R4 entry %0d done", i), done, 1);
    end

    // R3 R4 accumulation over a 10-bit window, alternating errors
    lane = 2'd0; csel = 4'd0; drive_lane(2'd0, 16'h0000, 2'd0, 1'b0);
    window = 16'd10; step();
    pulse_start();
    chk("R9 busy after start", busy, 1);
    for (int i = 0; i < 10; i++) begin
      spare = (i % 2 == 0); valid = 1'b1; step();
      if (i == 4) begin
        chk("R3 mid bits", bit_cnt, 5); chk("R4 mid busy", busy, 1); chk("R4 mid done", done, 0);
      end
    end
    chk("R3 window errs", err_cnt, 5); chk("R4 window bits", bit_cnt, 10);
    chk("R4 done", done, 1); chk("R4 busy", busy, 0);
    spare = 1'b1;
    repeat (3) step();
    valid = 1'b0;
    chk("R4 frozen errs", err_cnt, 5); chk("R4 frozen bits", bit_cnt, 10);

    // R6 clear
    clear = 1'b1; step(); clear = 1'b0;
    chk("R6 errs", err_cnt, 0); chk("R6 bits", bit_cnt, 0); chk("R6 done", done, 0);

    // R7 abort on comparator change
    window = 16'd100; pulse_start();
    valid = 1'b1; repeat (4) step();
    chk("R7 pre bits", bit_cnt, 4);
    csel = 4'd1; step(); valid = 1'b0;
    chk("R7 bits", bit_cnt, 0); chk("R7 errs", err_cnt, 0); chk("R7 busy", busy, 0);
    // R7 abort on lane change, priority over start
    pulse_start(); valid = 1'b1; repeat (3) step(); valid = 1'b0;
    lane = 2'd1; start = 1'b1; step(); start = 1'b0;
    chk("R7 lane bits", bit_cnt, 0); chk("R7 lane busy", busy, 0);

    // R5 saturation
    lane = 2'd0; csel = 4'd0; spare = 1'b1; drive_lane(2'd0, 16'h0000, 2'd0, 1'b0);
    window = 16'd2100; step();
    pulse_start();
    valid = 1'b1; repeat (2100) step(); valid = 1'b0;
    chk("R5 errs", err_cnt, 2047); chk("R5 bits", bit_cnt, 2100); chk("R5 done", done, 1);

    // R8 PRBS clean
    prbs_mode = 1'b1; window = 16'd100; gen = 31'h1234_5678;
    pulse_start();
    for (int i = 0; i < 131; i++) begin
      dec = {4{prbs_next()}}; valid = 1'b1; step();
      if (i == 30) chk("R8 seed not counted", bit_cnt, 0);
    end
    valid = 1'b0;
    chk("R8 clean errs", err_cnt, 0); chk("R8 clean bits", bit_cnt, 100); chk("R8 done", done, 1);

    // R8 PRBS with three injected errors
    gen = 31'h0ABC_DEF1;
    pulse_start();
    for (int i = 0; i < 131; i++) begin
      logic b;
      b = prbs_next();
      if (i == 71 || i == 72 || i == 121) b = ~b;
      dec = {4{b}}; valid = 1'b1; step();
    end
    valid = 1'b0;
    chk("R8 injected errs", err_cnt, 3); chk("R8 injected bits", bit_cnt, 100);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule